// File: doc/BRIEF.md
# DMA Controller Host Register File

This block is the software-facing register file of a four-channel DMA controller. A host reaches it through a narrow I/O bus: a 4-bit port offset, 8-bit write and read data, and one-cycle read and write strobes. Each channel keeps a 16-bit transfer address and a 16-bit transfer count. Each of these exists twice, as a base copy and a current copy. The block also keeps a mask bit and a mode field per channel, one command byte and a terminal-count status nibble. All stored values go to the transfer engine as plain outputs. The engine, channel arbitration and the upper-address (page) registers sit outside this block.

Every 16-bit register is reached through one byte-wide port. A single byte-order toggle is shared by all channels and decides whether an access moves the low or the high half. Software clears the toggle first and then makes byte accesses in pairs, low half first. Mask bits change in three ways: an encoded command for a single channel, a write of all four bits together, or a clear of all four. The count is stored exactly as written, and software writes one less than the number of transfers it wants.

Top module: `dmac_regfile`

## Requirements
- R1: After a synchronous active-low reset, all four mask bits are 1. Addresses, counts, modes, the command byte, the status bits, the byte-order toggle and the read data are all 0.
- R2: A write to offset 2n (n = 0..3) loads one byte of channel n's address into both the base and the current copy. The byte is the low half when the toggle is 0 and the high half when it is 1. No other channel changes.
- R3: A write to offset 2n+1 loads channel n's count in the same way. The count is stored unchanged (transfers minus one), so 0xFFFF is a legal value.
- R4: A read of offset 2n or 2n+1 returns the byte of channel n's current address or current count that the toggle selects. Read data is registered: it appears the cycle after the strobe and holds until the next read.
- R5: Every read or write of offsets 0x0 to 0x7 inverts the one shared toggle, whichever channel the access addresses.
- R6: A write to offset 0xC clears the toggle, whatever the data.
- R7: A write to offset 0xA changes one mask bit. Data bits 1:0 pick the channel. Data bit 2 equal to 1 masks that channel and 0 unmasks it.
- R8: A write to offset 0xF sets the four mask bits from data bits 3:0 (bit n is channel n). A write to offset 0xE clears all four.
- R9: A write to offset 0xB stores data bits 7:2 as the mode of the channel in data bits 1:0. Other channels keep their mode. The mode output of channel n is bits 6n+5:6n.
- R10: A write to offset 0xD (master clear) sets all mask bits and clears the toggle, the command byte and the status bits. Addresses, counts and modes keep their values.
- R11: A write to offset 0x8 stores the command byte on the command output. A read of offset 0x8 returns the status byte, with bits 7:4 = 0 and bit n = terminal count of channel n.
- R12: A 1 on tc_in bit n sets status bit n. A status read clears the bits it returned. A tc_in pulse in the same cycle as the read stays set.
- R13: A read of offset 0x9 or 0xA to 0xF returns 0x00 and leaves the toggle and all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 4 | Port offset |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Registered read data |
| tc_in | input | 4 | Terminal-count pulses from the engine, one bit per channel |
| base_addr_o | output | 64 | Base address, channel n at bits 16n+15:16n |
| cur_addr_o | output | 64 | Current address, same packing |
| base_cnt_o | output | 64 | Base count, same packing |
| cur_cnt_o | output | 64 | Current count, same packing |
| mask_o | output | 4 | Mask bit per channel |
| mode_o | output | 24 | Mode field per channel, 6 bits each |
| cmd_o | output | 8 | Command byte |

## Verification
The properties assume that the host never raises the read and write strobes in the same cycle. One property states this assumption explicitly. Each access lasts exactly one strobe cycle. The stimulus builds every access, random or directed, through one bench task that asserts only one strobe. It can overlap terminal-count pulses with any access, including status reads and master clear, so that the set-over-clear ordering is exercised.

// File: rtl/dmac_pkg.sv
// Package: shared sizes and control-port offsets of the DMA host register file.
// Assumes: four channels; word ports occupy offsets 0..7, control ports 8..15.
package dmac_pkg;
    localparam int CH_N     = 4;
    localparam int DATA_W   = 8;
    localparam int WORD_W   = 2 * DATA_W;
    localparam int PORT_W   = 4;
    localparam int MODE_W   = DATA_W - 2;
    localparam int CH_SEL_W = $clog2(CH_N);

    // Control port offsets; decoded by the register file and its checker.
    typedef enum logic [PORT_W-1:0] {
        P_CMD     = 4'h8,
        P_REQ     = 4'h9,
        P_MASK1   = 4'hA,
        P_MODE    = 4'hB,
        P_PTRCLR  = 4'hC,
        P_MCLR    = 4'hD,
        P_UNMASK  = 4'hE,
        P_MASKALL = 4'hF
    } ctl_port_e;
endpackage

// File: rtl/dmac_word_reg.sv
// Module: one 16-bit register kept as a base and a current copy, loaded a byte
// at a time. Assumes WORD_W is exactly twice DATA_W; hi_sel picks the half.
module dmac_word_reg #(
    parameter int DATA_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              hi_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [WORD_W-1:0] base_q,
    output logic [WORD_W-1:0] cur_q
);
    // Byte load into both copies; the half follows the shared byte toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (wr_en) begin
            if (hi_sel) begin
                base_q[WORD_W-1:DATA_W] <= wdata;
                cur_q[WORD_W-1:DATA_W]  <= wdata;
            end else begin
                base_q[DATA_W-1:0] <= wdata;
                cur_q[DATA_W-1:0]  <= wdata;
            end
        end
    end
endmodule

// File: rtl/dmac_ctrl_regs.sv
// Module: control state of the register file: byte toggle, masks, modes,
// command and terminal-count status. Assumes io strobes are never both high.
module dmac_ctrl_regs
    import dmac_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_stb,
    input  logic                   rd_stb,
    input  logic [PORT_W-1:0]      port,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [CH_N-1:0]        tc_in,
    output logic                   byte_ptr,
    output logic [CH_N-1:0]        mask_q,
    output logic [CH_N*MODE_W-1:0] mode_q,
    output logic [DATA_W-1:0]      cmd_q,
    output logic [CH_N-1:0]        status_q
);
    logic                word_acc;
    logic                wr_mclr;
    logic                wr_ptrclr;
    logic                rd_status;
    logic [CH_SEL_W-1:0] wsel;

    // Decode of the strobed control accesses.
    always_comb begin
        word_acc  = (wr_stb || rd_stb) && !port[PORT_W-1];
        wr_mclr   = wr_stb && (port == P_MCLR);
        wr_ptrclr = wr_stb && (port == P_PTRCLR);
        rd_status = rd_stb && (port == P_CMD);
        wsel      = wdata[CH_SEL_W-1:0];
    end

    // Shared byte toggle: cleared by pointer-clear or master clear, flips per word access.
    always_ff @(posedge clk) begin
        if (!rst_n)                    byte_ptr <= 1'b0;
        else if (wr_mclr || wr_ptrclr) byte_ptr <= 1'b0;
        else if (word_acc)             byte_ptr <= ~byte_ptr;
    end

    // Mask bits: single-channel command, all-bits write, clear-all and master clear.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '1;
        else if (wr_stb) begin
            case (port)
                P_MASK1:   mask_q[wsel] <= wdata[CH_SEL_W];
                P_MASKALL: mask_q       <= wdata[CH_N-1:0];
                P_UNMASK:  mask_q       <= '0;
                P_MCLR:    mask_q       <= '1;
                default:   mask_q       <= mask_q;
            endcase
        end
    end

    // Command byte: loaded by its port, cleared by master clear.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_mclr)              cmd_q <= '0;
        else if (wr_stb && port == P_CMD)   cmd_q <= wdata;
    end

    // Status: terminal-count pulses set bits; status read or master clear drops old bits.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= ((rd_status || wr_mclr) ? '0 : status_q) | tc_in;
    end

    // Per-channel mode field, one register per channel.
    for (genvar g = 0; g < CH_N; g++) begin : g_mode
        // Load mode bits when the mode port addresses this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mode_q[g*MODE_W +: MODE_W] <= '0;
            else if (wr_stb && port == P_MODE && wsel == CH_SEL_W'(g))
                mode_q[g*MODE_W +: MODE_W] <= wdata[DATA_W-1:CH_SEL_W];
        end
    end
endmodule

// File: rtl/dmac_regfile.sv
// Module: top of the DMA host register file. Decodes the byte-wide port bus,
// holds address and count pairs per channel and registers read data.
// Assumes one strobe per access and never io_rd with io_wr.
module dmac_regfile
    import dmac_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PORT_W-1:0]      io_addr,
    input  logic [DATA_W-1:0]      io_wdata,
    input  logic                   io_wr,
    input  logic                   io_rd,
    output logic [DATA_W-1:0]      io_rdata,
    input  logic [CH_N-1:0]        tc_in,
    output logic [CH_N*WORD_W-1:0] base_addr_o,
    output logic [CH_N*WORD_W-1:0] cur_addr_o,
    output logic [CH_N*WORD_W-1:0] base_cnt_o,
    output logic [CH_N*WORD_W-1:0] cur_cnt_o,
    output logic [CH_N-1:0]        mask_o,
    output logic [CH_N*MODE_W-1:0] mode_o,
    output logic [DATA_W-1:0]      cmd_o
);
    logic                byte_ptr;
    logic [CH_N-1:0]     status_q;
    logic [WORD_W-1:0]   cur_addr_a [CH_N];
    logic [WORD_W-1:0]   cur_cnt_a  [CH_N];
    logic [CH_SEL_W-1:0] ch;
    logic [WORD_W-1:0]   rd_word;
    logic [DATA_W-1:0]   rd_mux;

    dmac_ctrl_regs u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (io_wr),
        .rd_stb   (io_rd),
        .port     (io_addr),
        .wdata    (io_wdata),
        .tc_in    (tc_in),
        .byte_ptr (byte_ptr),
        .mask_q   (mask_o),
        .mode_q   (mode_o),
        .cmd_q    (cmd_o),
        .status_q (status_q)
    );

    // Channel index of a word port.
    assign ch = io_addr[CH_SEL_W:1];

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        logic sel_ch;
        assign sel_ch = io_wr && !io_addr[PORT_W-1] && (ch == CH_SEL_W'(g));

        dmac_word_reg #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_addr (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (sel_ch && !io_addr[0]),
            .hi_sel (byte_ptr),
            .wdata  (io_wdata),
            .base_q (base_addr_o[g*WORD_W +: WORD_W]),
            .cur_q  (cur_addr_a[g])
        );

        dmac_word_reg #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (sel_ch && io_addr[0]),
            .hi_sel (byte_ptr),
            .wdata  (io_wdata),
            .base_q (base_cnt_o[g*WORD_W +: WORD_W]),
            .cur_q  (cur_cnt_a[g])
        );

        assign cur_addr_o[g*WORD_W +: WORD_W] = cur_addr_a[g];
        assign cur_cnt_o[g*WORD_W +: WORD_W]  = cur_cnt_a[g];
    end

    // Read selection: current word byte, status byte, or zero.
    always_comb begin
        rd_word = io_addr[0] ? cur_cnt_a[ch] : cur_addr_a[ch];
        if (!io_addr[PORT_W-1])
            rd_mux = byte_ptr ? rd_word[WORD_W-1:DATA_W] : rd_word[DATA_W-1:0];
        else if (io_addr == P_CMD)
            rd_mux = {{(DATA_W-CH_N){1'b0}}, status_q};
        else
            rd_mux = '0;
    end

    // Read data register, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     io_rdata <= '0;
        else if (io_rd) io_rdata <= rd_mux;
    end
endmodule

// File: rtl/dmac_regfile_chk.sv
// Module: assertion checker bound to dmac_regfile; observes ports and the
// byte toggle and status bits. Assumes strobes are exclusive.
module dmac_regfile_chk
    import dmac_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic [PORT_W-1:0]      io_addr,
    input logic [DATA_W-1:0]      io_wdata,
    input logic                   io_wr,
    input logic                   io_rd,
    input logic [CH_N-1:0]        tc_in,
    input logic                   byte_ptr,
    input logic [CH_N-1:0]        status_q,
    input logic [CH_N-1:0]        mask_o,
    input logic [DATA_W-1:0]      cmd_o,
    input logic [CH_N*WORD_W-1:0] base_addr_o
);
    a_in_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_rd));

    a_r5_ptr_flip: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_wr || io_rd) && !io_addr[PORT_W-1]) |=> (byte_ptr != $past(byte_ptr)));

    a_r6_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == P_PTRCLR) |=> !byte_ptr);

    a_r7_single_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == P_MASK1) |=> (mask_o[$past(io_wdata[1:0])] == $past(io_wdata[2])));

    a_r8_unmask_all: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == P_UNMASK) |=> (mask_o == '0));

    a_r10_master_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == P_MCLR) |=> (mask_o == '1 && !byte_ptr && cmd_o == '0));

    a_r12_status_read: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == P_CMD && tc_in == '0) |=> (status_q == '0));

    a_r12_tc_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_in != '0) |=> ((status_q & $past(tc_in)) == $past(tc_in)));

    a_r2_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> $stable(base_addr_o));

    a_r13_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr[PORT_W-1] ) |=> $stable(byte_ptr));
endmodule

bind dmac_regfile dmac_regfile_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_addr     (io_addr),
    .io_wdata    (io_wdata),
    .io_wr       (io_wr),
    .io_rd       (io_rd),
    .tc_in       (tc_in),
    .byte_ptr    (byte_ptr),
    .status_q    (status_q),
    .mask_o      (mask_o),
    .cmd_o       (cmd_o),
    .base_addr_o (base_addr_o)
);

// File: tb/tb_dmac_regfile.sv
// Bench: random and directed port accesses against a behavioural model.
module tb_dmac_regfile;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [3:0]  tc_in = '0;
    logic [7:0]  io_rdata;
    logic [63:0] base_addr_o, cur_addr_o, base_cnt_o, cur_cnt_o;
    logic [3:0]  mask_o;
    logic [23:0] mode_o;
    logic [7:0]  cmd_o;

    int n_chk = 0;
    int n_fail = 0;

    // Model state
    logic [15:0] m_addr [4];
    logic [15:0] m_cnt  [4];
    logic [5:0]  m_mode [4];
    logic [3:0]  m_mask, m_stat;
    logic [7:0]  m_cmd, m_rd;
    logic        m_ptr;

    dmac_regfile dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .tc_in(tc_in),
        .base_addr_o(base_addr_o), .cur_addr_o(cur_addr_o),
        .base_cnt_o(base_cnt_o), .cur_cnt_o(cur_cnt_o),
        .mask_o(mask_o), .mode_o(mode_o), .cmd_o(cmd_o)
    );

    always #(CLK_P/2) clk = ~clk;

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    function automatic logic [63:0] pack16(input logic [15:0] a [4]);
        logic [63:0] r;
        for (int i = 0; i < 4; i++) r[i*16 +: 16] = a[i];
        return r;
    endfunction

    function automatic logic [23:0] pack6(input logic [5:0] a [4]);
        logic [23:0] r;
        for (int i = 0; i < 4; i++) r[i*6 +: 6] = a[i];
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all();
        check("R2 base addr", base_addr_o, pack16(m_addr));
        check("R2 cur addr",  cur_addr_o,  pack16(m_addr));
        check("R3 base cnt",  base_cnt_o,  pack16(m_cnt));
        check("R3 cur cnt",   cur_cnt_o,   pack16(m_cnt));
        check("R7 mask",      {60'd0, mask_o}, {60'd0, m_mask});
        check("R9 mode",      {40'd0, mode_o}, {40'd0, pack6(m_mode)});
        check("R11 cmd",      {56'd0, cmd_o},  {56'd0, m_cmd});
        check("R4 rdata",     {56'd0, io_rdata}, {56'd0, m_rd});
    endtask

    // Model update for one access; strobe values follow the RTL requirements.
    task automatic model(input logic wr, input logic rd, input logic [3:0] a,
                         input logic [7:0] d, input logic [3:0] tc);
        int c = a[2:1];
        if (wr) begin
            if (!a[3]) begin
                if (a[0]) begin
                    if (m_ptr) m_cnt[c][15:8] = d; else m_cnt[c][7:0] = d;
                end else begin
                    if (m_ptr) m_addr[c][15:8] = d; else m_addr[c][7:0] = d;
                end
                m_ptr = ~m_ptr;
            end else begin
                case (a)
                    4'h8: m_cmd = d;
                    4'hA: m_mask[d[1:0]] = d[2];
                    4'hB: m_mode[d[1:0]] = d[7:2];
                    4'hC: m_ptr = 1'b0;
                    4'hD: begin m_mask = 4'hF; m_ptr = 1'b0; m_cmd = 8'h00; m_stat = 4'h0; end
                    4'hE: m_mask = 4'h0;
                    4'hF: m_mask = d[3:0];
                    default: ;
                endcase
            end
        end else if (rd) begin
            if (!a[3]) begin
                logic [15:0] w = a[0] ? m_cnt[c] : m_addr[c];
                m_rd = m_ptr ? w[15:8] : w[7:0];
                m_ptr = ~m_ptr;
            end else if (a == 4'h8) begin
                m_rd = {4'h0, m_stat};
                m_stat = 4'h0;
            end else begin
                m_rd = 8'h00;
            end
        end
        m_stat = m_stat | tc;
    endtask

    // One bus cycle driven at a falling edge; results compared at the next falling edge.
    task automatic op(input logic wr, input logic rd, input logic [3:0] a,
                      input logic [7:0] d, input logic [3:0] tc);
        io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d; tc_in = tc;
        model(wr, rd, a, d, tc);
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0; tc_in = '0;
        check_all();
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d); op(1'b1, 1'b0, a, d, 4'h0); endtask
    task automatic rd(input logic [3:0] a); op(1'b0, 1'b1, a, 8'h00, 4'h0); endtask

    initial begin
        logic [31:0] seed;
        for (int i = 0; i < 4; i++) begin m_addr[i] = '0; m_cnt[i] = '0; m_mode[i] = '0; end
        m_mask = 4'hF; m_stat = '0; m_cmd = '0; m_rd = '0; m_ptr = 1'b0;
        seed = $urandom(32'h5EED_0A11);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 mask reset", {60'd0, mask_o}, 64'hF);
        check("R1 addr reset", cur_addr_o | base_addr_o, 64'd0);
        check("R1 rdata reset", {56'd0, io_rdata}, 64'd0);
        check_all();

        // R2/R4: low then high address byte, read back
        wr(4'h0, 8'h34); wr(4'h0, 8'h12);
        check("R2 ch0 addr", {48'd0, cur_addr_o[15:0]}, 64'h1234);
        rd(4'h0); check("R4 low byte", {56'd0, io_rdata}, 64'h34);
        rd(4'h0); check("R4 high byte", {56'd0, io_rdata}, 64'h12);

        // R3: count written as transfers minus one, full range
        wr(4'h7, 8'hFF); wr(4'h7, 8'hFF);
        check("R3 ch3 count", {48'd0, base_cnt_o[63:48]}, 64'hFFFF);

        // R5: toggle shared across channels
        wr(4'h0, 8'hAA); wr(4'h5, 8'h5C);
        check("R5 shared toggle", {56'd0, cur_cnt_o[47:40]}, 64'h5C);

        // R6: pointer clear with any data
        wr(4'h2, 8'h11); wr(4'hC, 8'hFF); wr(4'h3, 8'h77);
        check("R6 low after clear", {56'd0, cur_cnt_o[23:16]}, 64'h77);
        wr(4'hC, 8'h00);

        // R7/R8: mask commands
        wr(4'hA, 8'h01); wr(4'hA, 8'h06);
        check("R7 single mask", {60'd0, mask_o}, 64'hD);
        wr(4'hE, 8'hFF); check("R8 clear all", {60'd0, mask_o}, 64'h0);
        wr(4'hF, 8'h0A); check("R8 write all", {60'd0, mask_o}, 64'hA);

        // R9: mode per channel
        wr(4'hB, 8'h46); wr(4'hB, 8'hC1);
        check("R9 mode ch2", {58'd0, mode_o[17:12]}, 64'h11);
        check("R9 mode ch1", {58'd0, mode_o[11:6]}, 64'h30);

        // R11/R12: command, status set, read clear, same-cycle pulse
        wr(4'h8, 8'hA5); check("R11 cmd", {56'd0, cmd_o}, 64'hA5);
        op(1'b0, 1'b0, 4'h0, 8'h00, 4'h5);
        op(1'b0, 1'b1, 4'h8, 8'h00, 4'h2);
        check("R12 status read", {56'd0, io_rdata}, 64'h05);
        rd(4'h8); check("R12 pulse kept", {56'd0, io_rdata}, 64'h02);
        rd(4'h8); check("R12 cleared", {56'd0, io_rdata}, 64'h00);

        // R10: master clear keeps addresses and modes
        wr(4'h0, 8'h99); op(1'b0, 1'b0, 4'h0, 8'h00, 4'h8);
        wr(4'hD, 8'h00);
        check("R10 masks set", {60'd0, mask_o}, 64'hF);
        check("R10 cmd clear", {56'd0, cmd_o}, 64'h00);
        check("R10 addr kept", {48'd0, cur_addr_o[15:0]}, 64'h1299);
        rd(4'h8); check("R10 status clear", {56'd0, io_rdata}, 64'h00);

        // R13: other reads give zero and leave the toggle
        wr(4'h4, 8'hDE); rd(4'hD);
        check("R13 temp reads zero", {56'd0, io_rdata}, 64'h00);
        rd(4'hF); rd(4'h9); wr(4'h4, 8'hAD);
        check("R13 toggle held", {48'd0, cur_addr_o[47:32]}, 64'hADDE);

        // Random mixture
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r = $urandom;
            logic is_wr = r[0];
            logic [3:0] tc = (r[7:5] == 3'd0) ? r[11:8] : 4'h0;
            op(is_wr, ~is_wr, r[15:12], r[23:16], tc);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule